// File: doc/BRIEF.md
# Tag-matching receive handler

This block is the receive half of a network adapter that sits between a packet input and a processor's private memory. The processor posts a receive by writing an expected tag, an expected sender number and a destination word address. Writing the destination arms the receive. Each arriving message is a header beat followed by one or more payload beats. If the header's tag and sender both equal the posted pair while a receive is armed, the payload is written word by word into memory from the destination upward. When the last word is written, a done bit is set for the processor to poll.

A message that finds no armed matching receive is not dropped and does not stall the network. Its payload is parked in a reserved region of the same memory, in one of a fixed number of slots. Each slot records the tag, sender and word count of its message. When a receive is later armed, the parked slots are searched, and the oldest matching message is copied from its slot to the destination. Its slot is then released. The input is held off only when a header must be parked and every slot is taken.

All work runs through a single engine, so only one of three things happens at a time: a direct delivery, parking a message, or a slot-to-destination copy. Polling the done bit gives blocking use. Reading it once gives non-blocking use.

Top module: `tagrx_handler`

## Requirements
- R1: A configuration write with `cfg_sel` 0 sets the expected tag, 1 sets the expected sender and 2 sets the destination address and arms the receive. One cycle after an accepted arm write, `stat_armed` is 1 and `stat_done` is 0.
- R2: A header beat (`in_first`=1) carries the tag in `in_data[15:0]` and the sender in `in_data[19:16]`. A message is delivered directly only if both fields equal the posted values. A message with a different tag or a different sender leaves `stat_done` 0 and `stat_armed` 1.
- R3: On a direct match, payload beat k (counting from 0) is written at destination address + k. On the beat carrying `in_last`, `stat_done` becomes 1 and `stat_armed` becomes 0.
- R4: A message that arrives with no armed matching receive is parked in a buffer slot. When a receive with its tag and sender is later armed, the parked payload is copied to the destination in order and `stat_done` then becomes 1.
- R5: When several parked messages match a newly armed receive, the one that arrived first is delivered, and the next arm delivers the next oldest.
- R6: A header that must be parked while all NSLOT slots hold messages sees `in_ready` low. The header is accepted once a copy has released a slot.
- R7: `stat_done` stays 1 until the next arm write, and that write clears it.
- R8: A posted receive consumes exactly one message. A second matching message arriving after the first has completed is parked, not written over the destination.
- R9: While a delivery or copy for the posted receive is in progress, `stat_busy` is 1 and configuration writes are ignored. A destination write in that window neither redirects the data nor re-arms.
- R10: After reset `stat_armed`, `stat_done` and `stat_busy` are 0, and `stat_done` and `stat_armed` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 tag, 1 sender, 2 destination (arms) |
| cfg_wdata | input | CFG_W | Configuration write data |
| stat_armed | output | 1 | A receive is posted and not yet completed |
| stat_done | output | 1 | The posted receive has completed |
| stat_busy | output | 1 | The data of the posted receive is being moved |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_first | input | 1 | Beat is a header |
| in_last | input | 1 | Beat is the final payload beat |
| in_data | input | DW | Header fields or payload word |
| mem_we | output | 1 | Memory write enable |
| mem_waddr | output | AW | Memory write word address |
| mem_wdata | output | DW | Memory write data |
| mem_re | output | 1 | Memory read enable (data one cycle later) |
| mem_raddr | output | AW | Memory read word address |
| mem_rdata | input | DW | Memory read data |

## Verification
Messages are sent both after the matching receive is posted and before it, so the direct write path and the park-then-copy path are each shown to place the same words at the destination. Headers that differ only in tag or only in sender show that the compare needs both fields. Two same-key parked messages of different lengths distinguish oldest-first selection from any other pick. A fifth early message against four full slots separates back-pressure from dropping or overwriting. A destination write during a live delivery, and a second matching message after a completed one, show that a posted receive is bound to exactly one message. Random keys, lengths, destinations and orderings then go through both paths many times.

// File: rtl/tagrx_pkg.sv
package tagrx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DELIVER = 2'd1,
        ST_PARK    = 2'd2,
        ST_COPY    = 2'd3
    } eng_state_e;

    localparam logic [1:0] SEL_TAG  = 2'd0;
    localparam logic [1:0] SEL_SRC  = 2'd1;
    localparam logic [1:0] SEL_DEST = 2'd2;

    // Word address of the first location of a parking slot.
    function automatic int unsigned slot_base(int unsigned region, int unsigned words,
                                              int unsigned idx);
        return region + idx * words;
    endfunction

endpackage

// File: rtl/tagrx_cfg.sv
module tagrx_cfg
    import tagrx_pkg::*;
#(
    parameter int TAG_W = 16,
    parameter int SRC_W = 4,
    parameter int AW    = 10,
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             lock,
    output logic [TAG_W-1:0] exp_tag,
    output logic [SRC_W-1:0] exp_src,
    output logic [AW-1:0]    dest,
    output logic             arm_pulse
);
    logic wr_ok;

    assign wr_ok     = cfg_we && !lock;
    assign arm_pulse = wr_ok && (cfg_sel == SEL_DEST);

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_tag <= '0;
            exp_src <= '0;
            dest    <= '0;
        end else if (wr_ok) begin
            case (cfg_sel)
                SEL_TAG:  exp_tag <= cfg_wdata[TAG_W-1:0];
                SEL_SRC:  exp_src <= cfg_wdata[SRC_W-1:0];
                SEL_DEST: dest    <= cfg_wdata[AW-1:0];
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/tagrx_park_table.sv
module tagrx_park_table #(
    parameter int  NSLOT = 4,
    parameter int  TAG_W = 16,
    parameter int  SRC_W = 4,
    parameter int  LEN_W = 4,
    localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             park_en,
    input  logic [IDX_W-1:0] park_idx,
    input  logic [TAG_W-1:0] park_tag,
    input  logic [SRC_W-1:0] park_src,
    input  logic [LEN_W-1:0] park_len,
    input  logic             free_en,
    input  logic [IDX_W-1:0] free_idx,
    input  logic [TAG_W-1:0] srch_tag,
    input  logic [SRC_W-1:0] srch_src,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [LEN_W-1:0] hit_len,
    output logic             has_free,
    output logic [IDX_W-1:0] free_slot
);
    // Age is a rank: 0 for the newest valid slot, larger for older ones.
    logic             v   [NSLOT];
    logic [TAG_W-1:0] t   [NSLOT];
    logic [SRC_W-1:0] s   [NSLOT];
    logic [LEN_W-1:0] l   [NSLOT];
    logic [IDX_W-1:0] age [NSLOT];
    logic [IDX_W-1:0] free_age;
    logic [IDX_W-1:0] best;

    assign free_age = age[free_idx];
    assign hit_len  = l[hit_idx];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NSLOT; i++) begin
            if (rst) begin
                v[i]   <= 1'b0;
                t[i]   <= '0;
                s[i]   <= '0;
                l[i]   <= '0;
                age[i] <= '0;
            end else if (park_en) begin
                if (park_idx == IDX_W'(i)) begin
                    v[i]   <= 1'b1;
                    t[i]   <= park_tag;
                    s[i]   <= park_src;
                    l[i]   <= park_len;
                    age[i] <= '0;
                end else if (v[i]) begin
                    age[i] <= age[i] + 1'b1;
                end
            end else if (free_en) begin
                if (free_idx == IDX_W'(i)) begin
                    v[i] <= 1'b0;
                end else if (v[i] && age[i] > free_age) begin
                    age[i] <= age[i] - 1'b1;
                end
            end
        end
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        best    = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (v[i] && t[i] == srch_tag && s[i] == srch_src && (!hit || age[i] > best)) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
                best    = age[i];
            end
        end
    end

    always_comb begin
        has_free  = 1'b0;
        free_slot = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (!v[i]) begin
                has_free  = 1'b1;
                free_slot = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tagrx_handler.sv
module tagrx_handler
    import tagrx_pkg::*;
#(
    parameter int TAG_W    = 16,
    parameter int SRC_W    = 4,
    parameter int DW       = 32,
    parameter int AW       = 10,
    parameter int NSLOT    = 4,
    parameter int SLOT_W   = 8,
    parameter int BUF_BASE = 896,
    parameter int CFG_W    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             stat_armed,
    output logic             stat_done,
    output logic             stat_busy,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_first,
    input  logic             in_last,
    input  logic [DW-1:0]    in_data,
    output logic             mem_we,
    output logic [AW-1:0]    mem_waddr,
    output logic [DW-1:0]    mem_wdata,
    output logic             mem_re,
    output logic [AW-1:0]    mem_raddr,
    input  logic [DW-1:0]    mem_rdata
);
    localparam int LEN_W = $clog2(SLOT_W) + 1;
    localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    eng_state_e       state;
    logic             armed, done, claimed, search_req, pipe_v;
    logic [TAG_W-1:0] exp_tag, hdr_tag_q, hdr_tag;
    logic [SRC_W-1:0] exp_src, hdr_src_q, hdr_src;
    logic [AW-1:0]    dest, cur_addr, slot_addr;
    logic [IDX_W-1:0] slot_sel, hit_idx, free_slot;
    logic [LEN_W-1:0] cnt, len, rd_cnt, hit_len, park_len;
    logic             arm_pulse, hit, has_free, hdr_match;
    logic             cnt_room, park_en, copy_done;

    tagrx_cfg #(.TAG_W(TAG_W), .SRC_W(SRC_W), .AW(AW), .CFG_W(CFG_W)) u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .lock(claimed), .exp_tag(exp_tag), .exp_src(exp_src), .dest(dest),
        .arm_pulse(arm_pulse)
    );

    tagrx_park_table #(.NSLOT(NSLOT), .TAG_W(TAG_W), .SRC_W(SRC_W), .LEN_W(LEN_W)) u_table (
        .clk(clk), .rst(rst),
        .park_en(park_en), .park_idx(slot_sel), .park_tag(hdr_tag_q), .park_src(hdr_src_q),
        .park_len(park_len), .free_en(copy_done), .free_idx(slot_sel),
        .srch_tag(exp_tag), .srch_src(exp_src),
        .hit(hit), .hit_idx(hit_idx), .hit_len(hit_len),
        .has_free(has_free), .free_slot(free_slot)
    );

    assign hdr_tag    = in_data[TAG_W-1:0];
    assign hdr_src    = in_data[TAG_W +: SRC_W];
    assign hdr_match  = armed && !claimed && hdr_tag == exp_tag && hdr_src == exp_src;
    assign slot_addr  = AW'(slot_base(BUF_BASE, SLOT_W, int'(slot_sel)));
    assign cnt_room   = cnt < LEN_W'(SLOT_W);
    assign park_en    = (state == ST_PARK) && in_valid && in_last;
    assign park_len   = cnt_room ? cnt + 1'b1 : cnt;
    assign copy_done  = (state == ST_COPY) && rd_cnt == len && !pipe_v;
    assign mem_re     = (state == ST_COPY) && rd_cnt != len;
    assign mem_raddr  = slot_addr + AW'(rd_cnt);
    assign stat_armed = armed;
    assign stat_done  = done;
    assign stat_busy  = claimed;

    always_comb begin
        in_ready  = 1'b0;
        mem_we    = 1'b0;
        mem_waddr = cur_addr;
        mem_wdata = in_data;
        case (state)
            ST_IDLE:    in_ready = !cfg_we && !search_req && (!in_first || hdr_match || has_free);
            ST_DELIVER: begin
                in_ready = 1'b1;
                mem_we   = in_valid;
            end
            ST_PARK: begin
                in_ready  = 1'b1;
                mem_we    = in_valid && cnt_room;
                mem_waddr = slot_addr + AW'(cnt);
            end
            ST_COPY: begin
                mem_we    = pipe_v;
                mem_wdata = mem_rdata;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            armed      <= 1'b0;
            done       <= 1'b0;
            claimed    <= 1'b0;
            search_req <= 1'b0;
            pipe_v     <= 1'b0;
            cur_addr   <= '0;
            slot_sel   <= '0;
            cnt        <= '0;
            len        <= '0;
            rd_cnt     <= '0;
            hdr_tag_q  <= '0;
            hdr_src_q  <= '0;
        end else begin
            pipe_v <= mem_re;
            if (arm_pulse) begin
                armed      <= 1'b1;
                done       <= 1'b0;
                search_req <= 1'b1;
            end
            case (state)
                ST_IDLE: begin
                    if (!cfg_we) begin
                        if (search_req) begin
                            search_req <= 1'b0;
                            if (hit) begin
                                claimed  <= 1'b1;
                                slot_sel <= hit_idx;
                                len      <= hit_len;
                                rd_cnt   <= '0;
                                cur_addr <= dest;
                                state    <= ST_COPY;
                            end
                        end else if (in_valid && in_first) begin
                            if (hdr_match) begin
                                claimed  <= 1'b1;
                                cur_addr <= dest;
                                state    <= ST_DELIVER;
                            end else if (has_free) begin
                                slot_sel  <= free_slot;
                                hdr_tag_q <= hdr_tag;
                                hdr_src_q <= hdr_src;
                                cnt       <= '0;
                                state     <= ST_PARK;
                            end
                        end
                    end
                end
                ST_DELIVER: begin
                    if (in_valid) begin
                        cur_addr <= cur_addr + 1'b1;
                        if (in_last) begin
                            done    <= 1'b1;
                            armed   <= 1'b0;
                            claimed <= 1'b0;
                            state   <= ST_IDLE;
                        end
                    end
                end
                ST_PARK: begin
                    if (in_valid) begin
                        if (cnt_room) cnt <= cnt + 1'b1;
                        if (in_last) state <= ST_IDLE;
                    end
                end
                ST_COPY: begin
                    if (mem_re) rd_cnt <= rd_cnt + 1'b1;
                    if (pipe_v) cur_addr <= cur_addr + 1'b1;
                    if (copy_done) begin
                        done    <= 1'b1;
                        armed   <= 1'b0;
                        claimed <= 1'b0;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tagrx_checker.sv
module tagrx_checker
    import tagrx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cfg_we,
    input logic [1:0] cfg_sel,
    input logic       stat_armed,
    input logic       stat_done,
    input logic       stat_busy,
    input logic       mem_re
);
    AST_ARM_SETS: assert property (@(posedge clk) disable iff (rst)
        cfg_we && cfg_sel == SEL_DEST && !stat_busy |=> stat_armed && !stat_done); // R1

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        stat_done && !(cfg_we && cfg_sel == SEL_DEST) |=> stat_done); // R7

    AST_BUSY_ARMED: assert property (@(posedge clk) disable iff (rst)
        stat_busy |-> stat_armed); // R9

    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
        stat_busy |=> stat_busy || stat_done); // R9

    AST_DONE_ARMED_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(stat_done && stat_armed)); // R10

    AST_READ_ONLY_COPY: assert property (@(posedge clk) disable iff (rst)
        mem_re |-> stat_busy); // R4
endmodule

bind tagrx_handler tagrx_checker u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .stat_armed(stat_armed), .stat_done(stat_done), .stat_busy(stat_busy),
    .mem_re(mem_re)
);

// File: tb/tagrx_handler_bench.sv
`timescale 1ns/1ps
module tagrx_handler_bench;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int MEMW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [15:0]   cfg_wdata = '0;
    logic          stat_armed, stat_done, stat_busy;
    logic          in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          mem_we, mem_re;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [DW-1:0] mem [MEMW];

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    tagrx_handler u_tagrx_handler (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .stat_armed(stat_armed), .stat_done(stat_done), .stat_busy(stat_busy),
        .in_valid(in_valid), .in_ready(in_ready), .in_first(in_first), .in_last(in_last),
        .in_data(in_data), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_waddr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_raddr];
    end

    function automatic logic [31:0] sentinel(int a);
        return 32'hDEAD0000 | 32'(a);
    endfunction

    function automatic logic [31:0] pay(logic [15:0] tag, int salt, int i);
        return {tag, 8'(salt), 8'(i)};
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic post(logic [15:0] tag, logic [3:0] src, int dst);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = tag;
        @(negedge clk); cfg_sel = 2'd1; cfg_wdata = 16'(src);
        @(negedge clk); cfg_sel = 2'd2; cfg_wdata = 16'(dst);
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic beat(logic first, logic last, logic [31:0] d);
        in_valid = 1'b1; in_first = first; in_last = last; in_data = d;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    endtask

    task automatic send_hdr(logic [15:0] tag, logic [3:0] src);
        @(negedge clk);
        beat(1'b1, 1'b0, {12'h0, src, tag});
    endtask

    task automatic send_beats(logic [15:0] tag, int salt, int len);
        @(negedge clk);
        for (int i = 0; i < len; i++) beat(1'b0, i == len - 1, pay(tag, salt, i));
    endtask

    task automatic send(logic [15:0] tag, logic [3:0] src, int salt, int len);
        send_hdr(tag, src);
        send_beats(tag, salt, len);
    endtask

    task automatic wait_done(string req);
        int n = 0;
        @(negedge clk); #1;
        while (!stat_done && n < 200) begin @(negedge clk); #1; n++; end
        chk(stat_done === 1'b1 && stat_armed === 1'b0, req, {30'h0, stat_done, stat_armed}, 32'h2);
    endtask

    task automatic check_block(string req, int dst, logic [15:0] tag, int salt, int len);
        logic [31:0] a = '0, e = '0;
        bit ok = 1'b1;
        for (int i = 0; i < len; i++) begin
            if (ok && mem[dst + i] !== pay(tag, salt, i)) begin
                ok = 1'b0; a = mem[dst + i]; e = pay(tag, salt, i);
            end
        end
        chk(ok, req, a, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20511));
        for (int i = 0; i < MEMW; i++) mem[i] = sentinel(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R10: reset state
        chk(!stat_armed && !stat_done && !stat_busy, "R10 reset", {29'h0, stat_armed, stat_done, stat_busy}, 0);

        // R1, R3: post first, then matching message
        post(16'h0011, 4'd2, 10);
        #1;
        chk(stat_armed === 1'b1 && stat_done === 1'b0, "R1 arm", {30'h0, stat_armed, stat_done}, 32'h2);
        send(16'h0011, 4'd2, 1, 5);
        wait_done("R3 done");
        check_block("R3 data", 10, 16'h0011, 1, 5);
        chk(mem[15] === sentinel(15), "R3 no overrun", mem[15], sentinel(15));

        // R7: done sticky, cleared by re-arm
        repeat (5) @(negedge clk);
        #1;
        chk(stat_done === 1'b1, "R7 sticky", {31'h0, stat_done}, 1);

        // R2: tag and sender both required
        post(16'h0090, 4'd5, 500);
        #1;
        chk(stat_done === 1'b0, "R7 rearm clears", {31'h0, stat_done}, 0);
        send(16'h0090, 4'd6, 2, 2);
        send(16'h0091, 4'd5, 3, 2);
        @(negedge clk); #1;
        chk(!stat_done && stat_armed, "R2 mismatch", {30'h0, stat_done, stat_armed}, 1);
        chk(mem[500] === sentinel(500), "R2 no write", mem[500], sentinel(500));
        send(16'h0090, 4'd5, 4, 3);
        wait_done("R2 match");
        check_block("R2 data", 500, 16'h0090, 4, 3);

        // R4: parked messages copied on post
        post(16'h0090, 4'd6, 520);
        wait_done("R4 done a");
        check_block("R4 copy a", 520, 16'h0090, 2, 2);
        post(16'h0091, 4'd5, 540);
        wait_done("R4 done b");
        check_block("R4 copy b", 540, 16'h0091, 3, 2);

        // R5: oldest first
        send(16'h0050, 4'd3, 1, 3);
        send(16'h0055, 4'd3, 9, 2);
        send(16'h0050, 4'd3, 2, 5);
        post(16'h0050, 4'd3, 100);
        wait_done("R5 first");
        check_block("R5 oldest", 100, 16'h0050, 1, 3);
        chk(mem[103] === sentinel(103), "R5 length", mem[103], sentinel(103));
        post(16'h0050, 4'd3, 200);
        wait_done("R5 second");
        check_block("R5 next", 200, 16'h0050, 2, 5);
        post(16'h0055, 4'd3, 220);
        wait_done("R5 drain");
        check_block("R5 other", 220, 16'h0055, 9, 2);

        // R6: full buffer back-pressure
        for (int k = 0; k < 4; k++) send(16'h0060 + 16'(k), 4'd1, k, 2);
        fork
            send(16'h0064, 4'd1, 4, 2);
            begin
                repeat (4) @(negedge clk);
                #1;
                chk(in_ready === 1'b0, "R6 backpressure", {31'h0, in_ready}, 0);
                post(16'h0060, 4'd1, 300);
            end
        join
        wait_done("R6 freed");
        check_block("R6 data", 300, 16'h0060, 0, 2);
        for (int k = 1; k < 5; k++) begin
            post(16'h0060 + 16'(k), 4'd1, 300 + 4 * k);
            wait_done("R6 drain");
            check_block("R6 drain data", 300 + 4 * k, 16'h0060 + 16'(k), k, 2);
        end

        // R8: one message per posted receive
        post(16'h0070, 4'd2, 400);
        send(16'h0070, 4'd2, 1, 4);
        send(16'h0070, 4'd2, 2, 4);
        @(negedge clk);
        check_block("R8 first kept", 400, 16'h0070, 1, 4);
        post(16'h0070, 4'd2, 450);
        wait_done("R8 second");
        check_block("R8 parked", 450, 16'h0070, 2, 4);

        // R9: cfg writes ignored during delivery
        post(16'h00A0, 4'd7, 600);
        send_hdr(16'h00A0, 4'd7);
        #1;
        chk(stat_busy === 1'b1, "R9 busy", {31'h0, stat_busy}, 1);
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 16'd650;
        @(negedge clk); cfg_we = 1'b0;
        send_beats(16'h00A0, 5, 3);
        wait_done("R9 done");
        check_block("R9 data", 600, 16'h00A0, 5, 3);
        chk(mem[650] === sentinel(650), "R9 no redirect", mem[650], sentinel(650));
        repeat (3) @(negedge clk); #1;
        chk(!stat_armed && !stat_busy, "R9 no rearm", {30'h0, stat_armed, stat_busy}, 0);

        // Random mix of both orders
        for (int k = 0; k < 40; k++) begin
            logic [15:0] tag = 16'h8000 | 16'($urandom_range(0, 16'h7FFF));
            logic [3:0]  src = 4'($urandom_range(0, 15));
            int          len = $urandom_range(1, 8);
            int          dst = $urandom_range(0, 700);
            if ($urandom_range(0, 1) == 1) begin
                post(tag, src, dst);
                send(tag, src, k, len);
                wait_done("R3 random");
                check_block("R3 random data", dst, tag, k, len);
            end else begin
                send(tag, src, k, len);
                post(tag, src, dst);
                wait_done("R4 random");
                check_block("R4 random data", dst, tag, k, len);
            end
            #1;
            chk(!(stat_done && stat_armed), "R10 excl", {30'h0, stat_done, stat_armed}, 32'h2);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule